// File: doc/BRIEF.md
# Three-Channel Programmable Timer

This block holds three independent timer channels behind a simple word-addressed register port. Each channel has a 32-bit counter that software can load at any time, a reload value taken whenever the counter wraps, and two compare registers. A channel counts either every bus clock or every rising edge of its own external tick input, which is brought into the bus clock domain first. All channels share one direction setting: they count down unless the up-count bit is set.

Hardware events (compare hits and wraps) set sticky bits in a status register. Software clears them by writing ones. A mask register picks which status bits reach the single interrupt output. Writes take effect on the clock edge where `bus_wr_en` is sampled high. Reads are combinational from `bus_addr`, and the two low address bits are ignored.

Top module: `tri_timer`

## Requirements
- R1: Channel c (c = 0..2) has its registers at byte offset 16*c: counter at +0x0, reload at +0x4, compare A at +0x8, compare B at +0xC. The control word is at 0x30, status at 0x34 and mask at 0x38. Every one of these reads back what was last written or loaded, and an unmapped word reads zero.
- R2: A write to a counter loads the written value at that clock edge. The write wins over counting in the same cycle and raises no event.
- R3: While its enable bit is clear, a channel's counter keeps its value.
- R4: In the control word, channel c owns bits 3c (enable), 3c+1 (tick source) and 3c+2 (wrap event enable). With enable set and tick source 0, the counter changes by one on every bus clock edge.
- R5: Control bit 9 makes all channels count up. When it is clear, all channels count down.
- R6: A down-counting channel at zero that receives a tick loads its reload value instead of decrementing.
- R7: An up-counting channel at all ones that receives a tick loads its reload value instead of incrementing.
- R8: When a tick moves a counter onto the value of compare A or compare B, status bit 3c or 3c+1 is set. The bit is set on the same edge that the counter takes that value.
- R9: Wrap status bit 3c+2 is set on a wrap only when control bit 3c+2 is set.
- R10: Writing a 1 to a status bit clears it. A hardware set on the same edge wins over the clear.
- R11: `irq` is high exactly when some status bit is set and its mask bit is 0. A mask bit of 1 blocks that status bit.
- R12: With tick source 1, each rising edge on the channel's `ext_tick` bit advances the counter exactly once, however long the input stays high. Bus clocks do not advance it.
- R13: After reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 6 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_tick | input | 3 | External tick inputs, one per channel, asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a status-clear write that lands on the very edge where a compare hit sets the same bit. The bench reaches it by loading a known count into a free-running channel. It then counts the edges a write takes and places the compare value exactly where the counter will be on the write's own edge. Wraps at both ends of the range are reached in a few cycles by loading the counter close to zero or close to all ones. The external tick path is driven with inputs held high for several clocks, to show that each tick advances the counter only once.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

    // Register slot inside a channel bank (word index bits 1:0).
    typedef enum logic [1:0] {
        SLOT_CNT = 2'd0,
        SLOT_RLD = 2'd1,
        SLOT_CMA = 2'd2,
        SLOT_CMB = 2'd3
    } slot_e;

    // Per-channel field positions inside a control group.
    localparam int CTL_EN   = 0;
    localparam int CTL_SRC  = 1;
    localparam int CTL_WRIE = 2;

    // Per-channel field positions inside a status group.
    localparam int ST_CMA  = 0;
    localparam int ST_CMB  = 1;
    localparam int ST_WRAP = 2;

    localparam int BITS_PER_CH  = 3;
    localparam int BANK_WORDS   = 4;

endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], async_i};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pulse_o = sync_q.chain[STAGES-1] & ~sync_q.prev;

    // R12: a level held high yields one pulse, never two in a row
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tri_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             up_i,
    input  logic             tick_i,
    input  logic [3:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [CNT_W-1:0] cma_o,
    output logic [CNT_W-1:0] cmb_o,
    output logic             hit_a_o,
    output logic             hit_b_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [CNT_W-1:0] cma;
        logic [CNT_W-1:0] cmb;
    } chan_t;

    chan_t            chan_d, chan_q;
    logic             advance;
    logic             at_end;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        chan_d  = chan_q;
        advance = en_i & tick_i & ~wr_sel_i[SLOT_CNT];
        if (up_i) begin
            at_end  = (chan_q.cnt == {CNT_W{1'b1}});
            stepped = at_end ? chan_q.rld : chan_q.cnt + 1'b1;
        end else begin
            at_end  = (chan_q.cnt == '0);
            stepped = at_end ? chan_q.rld : chan_q.cnt - 1'b1;
        end

        if (wr_sel_i[SLOT_CNT]) chan_d.cnt = wdata_i;
        else if (advance)       chan_d.cnt = stepped;
        if (wr_sel_i[SLOT_RLD]) chan_d.rld = wdata_i;
        if (wr_sel_i[SLOT_CMA]) chan_d.cma = wdata_i;
        if (wr_sel_i[SLOT_CMB]) chan_d.cmb = wdata_i;

        wrap_o  = advance & at_end;
        hit_a_o = advance & (stepped == chan_q.cma);
        hit_b_o = advance & (stepped == chan_q.cmb);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign cnt_o = chan_q.cnt;
    assign rld_o = chan_q.rld;
    assign cma_o = chan_q.cma;
    assign cmb_o = chan_q.cmb;

    // R2: software load lands on the next edge
    a_r2_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel_i[SLOT_CNT] |=> cnt_o == $past(wdata_i));

    // R3: disabled channel without a write keeps its count
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_sel_i[SLOT_CNT]) |=> $stable(cnt_o));

    // R6/R7: a wrap leaves the reload value in the counter
    a_r6_reload_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> cnt_o == $past(rld_o));

    // R8: a compare hit means the counter now equals that compare value
    a_r8_hit_lands_on_cma: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a_o |=> cnt_o == $past(cma_o));

endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tri_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] ext_tick,
    output logic              irq
);
    localparam int CTRL_W  = BITS_PER_CH * NUM_CH + 1;
    localparam int ST_W    = BITS_PER_CH * NUM_CH;
    localparam int UP_BIT  = BITS_PER_CH * NUM_CH;
    localparam int WIX_W   = ADDR_W - 2;
    localparam logic [WIX_W-1:0] CTRL_WIX = WIX_W'(BANK_WORDS * NUM_CH);
    localparam logic [WIX_W-1:0] STAT_WIX = WIX_W'(BANK_WORDS * NUM_CH + 1);
    localparam logic [WIX_W-1:0] MASK_WIX = WIX_W'(BANK_WORDS * NUM_CH + 2);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [ST_W-1:0]   stat;
        logic [ST_W-1:0]   mask;
    } top_t;

    top_t top_d, top_q;

    logic [WIX_W-1:0]          wix;
    logic                      addr_unused;
    logic [BANK_WORDS*NUM_CH-1:0] wr_sel;
    logic [NUM_CH-1:0]         ext_pulse;
    logic [NUM_CH-1:0]         hit_a, hit_b, wrap;
    logic [ST_W-1:0]           set_vec;
    logic [ST_W-1:0]           clr_vec;
    logic                      wr_ctrl, wr_stat, wr_mask;
    logic [CNT_W-1:0]          ch_cnt [NUM_CH];
    logic [CNT_W-1:0]          ch_rld [NUM_CH];
    logic [CNT_W-1:0]          ch_cma [NUM_CH];
    logic [CNT_W-1:0]          ch_cmb [NUM_CH];

    assign wix         = bus_addr[ADDR_W-1:2];
    assign addr_unused = ^bus_addr[1:0];
    assign wr_ctrl     = bus_wr_en && (wix == CTRL_WIX);
    assign wr_stat     = bus_wr_en && (wix == STAT_WIX);
    assign wr_mask     = bus_wr_en && (wix == MASK_WIX);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar s = 0; s < BANK_WORDS; s++) begin : g_sel
            assign wr_sel[BANK_WORDS*c+s] =
                bus_wr_en && (wix == WIX_W'(BANK_WORDS*c+s));
        end

        tmr_tick_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ext_tick[c]),
            .pulse_o (ext_pulse[c])
        );

        tmr_channel #(.CNT_W(CNT_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (top_q.ctrl[BITS_PER_CH*c+CTL_EN]),
            .up_i     (top_q.ctrl[UP_BIT]),
            .tick_i   (top_q.ctrl[BITS_PER_CH*c+CTL_SRC] ? ext_pulse[c] : 1'b1),
            .wr_sel_i (wr_sel[BANK_WORDS*c +: BANK_WORDS]),
            .wdata_i  (bus_wdata),
            .cnt_o    (ch_cnt[c]),
            .rld_o    (ch_rld[c]),
            .cma_o    (ch_cma[c]),
            .cmb_o    (ch_cmb[c]),
            .hit_a_o  (hit_a[c]),
            .hit_b_o  (hit_b[c]),
            .wrap_o   (wrap[c])
        );

        assign set_vec[BITS_PER_CH*c+ST_CMA]  = hit_a[c];
        assign set_vec[BITS_PER_CH*c+ST_CMB]  = hit_b[c];
        assign set_vec[BITS_PER_CH*c+ST_WRAP] =
            wrap[c] & top_q.ctrl[BITS_PER_CH*c+CTL_WRIE];

        // R9: wrap status only rises with its event enable set
        a_r9_wrap_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(top_q.stat[BITS_PER_CH*c+ST_WRAP]) |->
                $past(top_q.ctrl[BITS_PER_CH*c+CTL_WRIE]));
    end

    always_comb begin
        top_d   = top_q;
        clr_vec = wr_stat ? bus_wdata[ST_W-1:0] : '0;
        if (wr_ctrl) top_d.ctrl = bus_wdata[CTRL_W-1:0];
        if (wr_mask) top_d.mask = bus_wdata[ST_W-1:0];
        top_d.stat = (top_q.stat & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wix[WIX_W-1:2] == (WIX_W-2)'(c)) begin
                case (slot_e'(wix[1:0]))
                    SLOT_CNT: bus_rdata = ch_cnt[c];
                    SLOT_RLD: bus_rdata = ch_rld[c];
                    SLOT_CMA: bus_rdata = ch_cma[c];
                    SLOT_CMB: bus_rdata = ch_cmb[c];
                    default:  bus_rdata = '0;
                endcase
            end
        end
        if (wix == CTRL_WIX) bus_rdata = CNT_W'(top_q.ctrl);
        if (wix == STAT_WIX) bus_rdata = CNT_W'(top_q.stat);
        if (wix == MASK_WIX) bus_rdata = CNT_W'(top_q.mask);
    end

    assign irq = |(top_q.stat & ~top_q.mask);

    // R10/R8: a status bit only rises on an edge that carried a hardware event
    a_r10_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((top_q.stat & ~$past(top_q.stat) & ~$past(set_vec)) == '0));

    for (genvar b = 0; b < ST_W; b++) begin : g_clr
        // R10: a clear with no competing event leaves the bit low
        a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat && bus_wdata[b] && !set_vec[b]) |=> !top_q.stat[b]);
    end

endmodule

// File: tb/test_tri_timer.sv
module test_tri_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ext_tick = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_timer i_tri_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .irq       (irq)
    );

    // {write, addr, data}; on reads data is the expected value (R1)
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b1, 6'h04, 32'hDEAD_BEEF}, {1'b0, 6'h04, 32'hDEAD_BEEF},
        {1'b1, 6'h08, 32'h0000_1234}, {1'b0, 6'h08, 32'h0000_1234},
        {1'b1, 6'h1C, 32'hA5A5_0F0F}, {1'b0, 6'h1C, 32'hA5A5_0F0F},
        {1'b1, 6'h20, 32'hCAFE_0001}, {1'b0, 6'h20, 32'hCAFE_0001},
        {1'b1, 6'h2C, 32'h8000_0000}, {1'b0, 6'h2C, 32'h8000_0000},
        {1'b1, 6'h30, 32'h0000_02B6}, {1'b0, 6'h30, 32'h0000_02B6},
        {1'b1, 6'h38, 32'h0000_01A5}, {1'b0, 6'h38, 32'h0000_01A5},
        {1'b1, 6'h14, 32'h7654_3210}, {1'b0, 6'h14, 32'h7654_3210},
        {1'b0, 6'h3C, 32'h0000_0000}, {1'b0, 6'h04, 32'hDEAD_BEEF}
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Write: one full clock; returns just after the next falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        #1;
    endtask

    // Read: no clock edge passes
    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_tick = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] got;

        do_reset();
        // R13: reset state
        rd(6'h00, got); chk("R13 counter", got, 32'h0);
        rd(6'h30, got); chk("R13 control", got, 32'h0);
        rd(6'h34, got); chk("R13 status", got, 32'h0);
        chk("R13 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][38]) wr(VEC[i][37:32], VEC[i][31:0]);
            else begin
                rd(VEC[i][37:32], got);
                chk("R1 readback", got, VEC[i][31:0]);
            end
        end

        // R4/R3: count down from 100, then stop
        do_reset();
        wr(6'h00, 32'd100);
        wr(6'h30, 32'h001);
        repeat (10) @(negedge clk);
        #1 rd(6'h00, got); chk("R4 down count", got, 32'd90);
        wr(6'h30, 32'h000);               // two more edges counted
        repeat (5) @(negedge clk);
        #1 rd(6'h00, got); chk("R3 hold when disabled", got, 32'd88);

        // R2: write while running
        do_reset();
        wr(6'h30, 32'h001);
        wr(6'h00, 32'd500);
        rd(6'h00, got); chk("R2 load overrides count", got, 32'd500);
        repeat (3) @(negedge clk);
        #1 rd(6'h00, got); chk("R4 continues after load", got, 32'd497);

        // R6/R8/R9: down wrap with wrap event disabled
        do_reset();
        wr(6'h04, 32'd50);
        wr(6'h00, 32'd2);
        wr(6'h30, 32'h001);
        repeat (4) @(negedge clk);        // 1, 0, wrap->50, 49
        #1 rd(6'h00, got); chk("R6 down wrap reload", got, 32'd49);
        rd(6'h34, got); chk("R9 no wrap status w/o enable; R8 both compares", got, 32'h3);
        wr(6'h34, 32'h3);
        rd(6'h34, got); chk("R10 write-one clear", got, 32'h0);
        wr(6'h30, 32'h005);
        wr(6'h00, 32'd1);
        repeat (2) @(negedge clk);        // 0, wrap->50
        #1 rd(6'h34, got); chk("R9 wrap status with enable", got, 32'h7);
        rd(6'h00, got); chk("R6 reload after software load", got, 32'd50);
        chk("R11 irq unmasked", {31'b0, irq}, 32'h1);
        wr(6'h38, 32'h7);
        chk("R11 irq fully masked", {31'b0, irq}, 32'h0);
        wr(6'h38, 32'h3);
        chk("R11 irq wrap bit unmasked", {31'b0, irq}, 32'h1);

        // R5/R7: up count through all ones
        do_reset();
        wr(6'h04, 32'd7);
        wr(6'h00, 32'hFFFF_FFFD);
        wr(6'h30, 32'h205);
        repeat (4) @(negedge clk);        // FE, FF, wrap->7, 8
        #1 rd(6'h00, got); chk("R5/R7 up wrap reload", got, 32'd8);
        rd(6'h34, got); chk("R7 up wrap status", got, 32'h4);

        // R10: clear collides with a compare-A hit on channel 1
        do_reset();
        wr(6'h18, 32'd18);
        wr(6'h1C, 32'h0000_FFFF);
        wr(6'h10, 32'd20);
        wr(6'h30, 32'h008);
        wr(6'h34, 32'h8);                 // edges: 19, then 18 with the clear
        rd(6'h34, got); chk("R10 set wins over clear; R8 compare A only", got, 32'h8);
        wr(6'h34, 32'h8);
        rd(6'h34, got); chk("R10 clear with no event", got, 32'h0);

        // R12: external ticks on channel 2
        do_reset();
        wr(6'h20, 32'd1000);
        wr(6'h30, 32'h0C0);
        for (int p = 0; p < 5; p++) begin
            ext_tick[2] = 1'b1;
            repeat (3) @(negedge clk);
            ext_tick[2] = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        #1 rd(6'h20, got); chk("R12 one step per external edge", got, 32'd995);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule